// File: doc/BRIEF.md
# Zero-Cross Triggered Two-Pass Waveform Sampler

This block sequences the capture of one voltage waveform and one current waveform for an AC power meter. Both waveforms are referenced to the same phase point, the zero crossing of the voltage waveform. The block never converts both channels in one burst. After a capture request it waits for a voltage zero-crossing pulse, which has already been debounced. It then runs a burst of conversions on the voltage channel only. When that burst is complete it waits for a fresh zero crossing and runs an identical burst on the current channel only. Conversions in each burst are paced by an external sample-rate tick, nominally 9.6 kHz.

The block drives the external converter with a convert strobe and a channel select. It takes each result back over a valid/ready handshake. Result k of each burst is written to slot k of that channel's buffer, so the two buffers overlay sample by sample on a common time axis. While either burst is running, a hold-off output is raised so that lower-priority activity, such as display refresh, is paused and cannot disturb the sampling instants. A one-cycle done pulse ends a successful capture. A one-cycle error pulse ends a capture in which no zero crossing arrived in time. The buffers can be read at any time through a small combinational read port.

Result handshake rules: a beat transfers only on a clock edge where `res_valid` and `res_ready` are both high. `res_ready` is high only while a conversion is outstanding. The source does not hold a beat that was refused; the block drops it, and it is never taken later.

Top module: `zc_two_pass_sampler`

## Requirements
- R1: After reset, all outputs are low (`hold_off`, `conv_start`, `done`, `err`, `res_ready`). In idle, zero-crossing pulses and ticks cause no conversion, and a `cap_req` pulse moves the block to arming for the voltage pass.
- R2: A burst starts only on a `zc_pulse` seen while arming. Zero-crossing pulses that arrive while idle or during a burst are ignored.
- R3: `conv_ch` is 0 (voltage) for every convert strobe of the first pass and 1 (current) for every convert strobe of the second pass.
- R4: The current pass arms only after the last voltage result has been written. It then needs a new `zc_pulse`. A pulse in the same cycle as that last voltage write does not start the current pass.
- R5: During a burst, `conv_start` is asserted in a cycle where `smp_tick` is high and no conversion is outstanding. At most one conversion is outstanding at a time, and each pass issues exactly N = 200 strobes.
- R6: The k-th accepted result of a pass (k = 0..N-1) is stored at index k of that pass's channel buffer (`rd_ch` 0 = voltage, 1 = current). `rd_data` returns the stored value, and returns 0 for any `rd_idx` of N or more.
- R7: `res_ready` is high exactly while a conversion is outstanding. A `res_valid` beat with `res_ready` low is discarded, and exactly one result is written per convert strobe.
- R8: `hold_off` is high in every cycle of both bursts and low in idle and in arming.
- R9: While arming, if `zc_pulse` has not arrived by the arming cycle whose count from 0 equals `arm_timeout`, the block returns to idle. It raises `err` for exactly the following cycle.
- R10: `done` is high for exactly one cycle, the cycle after the last current-pass result is written. The block is then idle and accepts a new `cap_req`.
- R11: A `cap_req` pulse that arrives outside idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req | input | 1 | Capture request pulse |
| zc_pulse | input | 1 | Debounced voltage zero-crossing pulse |
| smp_tick | input | 1 | Sample-rate tick |
| arm_timeout | input | TO_W | Arming timeout limit, in cycles |
| conv_start | output | 1 | Convert strobe to the ADC |
| conv_ch | output | 1 | Channel select: 0 voltage, 1 current |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Block can take a result (conversion outstanding) |
| res_data | input | DW | Conversion result |
| hold_off | output | 1 | Burst in progress; pause lower-priority work |
| done | output | 1 | One-cycle pulse: both buffers filled |
| err | output | 1 | One-cycle pulse: arming timed out |
| rd_ch | input | 1 | Buffer select for read |
| rd_idx | input | IW | Read index |
| rd_data | output | DW | Read data |

## Verification
The main same-cycle collision is the last voltage result being accepted in the very cycle a zero-crossing pulse arrives. The bench provokes this by raising the pulse on the same edge that it presents the 200th voltage result. It then judges from the per-cycle model that the block goes to arming for the current pass and waits for the next crossing, rather than starting on the early pulse. A second overlap is a stray result beat landing in the cycle right after an accepted one, with no conversion outstanding. The bench injects these throughout the bursts and checks that they leave the buffers untouched. It also checks that `cap_req` pulses during a burst and a zero crossing on the final arming cycle are handled as the requirements say.

// File: rtl/zcs_pkg.sv
package zcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_ARM_V   = 3'd1,
    S_BURST_V = 3'd2,
    S_ARM_I   = 3'd3,
    S_BURST_I = 3'd4
  } zcs_state_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/zcs_arm_timer.sv
module zcs_arm_timer #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arming,
  input  logic            zc_pulse,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic [TO_W-1:0] wait_cnt;

  assign expire = arming && !zc_pulse && (wait_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wait_cnt <= '0;
    else if (!arming)   wait_cnt <= '0;
    else if (!expire)   wait_cnt <= wait_cnt + 1'b1;
  end

  // R9: the count starts from zero on every entry to arming
  a_r9_count_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arming) |-> (wait_cnt == '0));
endmodule

// File: rtl/zcs_conv_ctrl.sv
module zcs_conv_ctrl #(
  parameter int unsigned N  = 200,
  parameter int unsigned IW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst,
  input  logic          smp_tick,
  input  logic          res_valid,
  output logic          conv_start,
  output logic          res_ready,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          last_wr
);
  localparam logic [IW-1:0] N_LAST = IW'(N - 1);
  localparam logic [IW-1:0] N_FULL = IW'(N);

  logic [IW-1:0] issued;
  logic [IW-1:0] written;
  logic          pend;

  assign conv_start = burst && smp_tick && !pend && (issued != N_FULL);
  assign res_ready  = pend;
  assign wr_en      = res_valid && pend;
  assign wr_idx     = written;
  assign last_wr    = wr_en && (written == N_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued  <= '0;
      written <= '0;
      pend    <= 1'b0;
    end else if (!burst) begin
      issued  <= '0;
      written <= '0;
      pend    <= 1'b0;
    end else begin
      if (conv_start) begin
        pend   <= 1'b1;
        issued <= issued + 1'b1;
      end
      if (wr_en) begin
        pend    <= 1'b0;
        written <= written + 1'b1;
      end
    end
  end

  // R5: strobes issued never run ahead of writes by more than the one outstanding
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    issued == written + IW'(pend));
  // R5: never more than N strobes in a pass
  a_r5_pass_cap: assert property (@(posedge clk) disable iff (!rst_n)
    issued <= N_FULL);
  // R7: an accepted result clears the outstanding conversion
  a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && burst) |=> !res_ready);
endmodule

// File: rtl/zcs_wave_store.sv
module zcs_wave_store #(
  parameter int unsigned N  = 200,
  parameter int unsigned DW = 12,
  parameter int unsigned IW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_ch,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ch,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  import zcs_pkg::*;

  localparam logic [IW-1:0] N_FULL = IW'(N);

  logic          rd_ok;
  logic [IW-1:0] rd_a;
  logic [DW-1:0] ch_rd [NUM_CH];

  assign rd_ok = (rd_idx < N_FULL);
  assign rd_a  = rd_ok ? rd_idx : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DW-1:0] mem [N];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ch == 1'(g)))
        mem[wr_idx] <= wr_data;
    end
    assign ch_rd[g] = mem[rd_a];
  end

  assign rd_data = rd_ok ? ch_rd[rd_ch] : '0;

  // R6: writes land only inside the buffer
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < N_FULL));
endmodule

// File: rtl/zc_two_pass_sampler.sv
module zc_two_pass_sampler #(
  parameter int unsigned N    = 200,
  parameter int unsigned DW   = 12,
  parameter int unsigned TO_W = 16,
  parameter int unsigned IW   = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_req,
  input  logic            zc_pulse,
  input  logic            smp_tick,
  input  logic [TO_W-1:0] arm_timeout,
  output logic            conv_start,
  output logic            conv_ch,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic [DW-1:0]   res_data,
  output logic            hold_off,
  output logic            done,
  output logic            err,
  input  logic            rd_ch,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data
);
  import zcs_pkg::*;

  zcs_state_e    state, state_nx;
  logic          arming, burst, expire, wr_en, last_wr;
  logic [IW-1:0] wr_idx;
  logic          done_q, err_q, done_nx, err_nx;

  assign arming   = (state == S_ARM_V)   || (state == S_ARM_I);
  assign burst    = (state == S_BURST_V) || (state == S_BURST_I);
  assign conv_ch  = (state == S_BURST_I) || (state == S_ARM_I);
  assign hold_off = burst;
  assign done     = done_q;
  assign err      = err_q;

  zcs_arm_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arming(arming), .zc_pulse(zc_pulse),
    .limit(arm_timeout), .expire(expire)
  );

  zcs_conv_ctrl #(.N(N), .IW(IW)) u_conv (
    .clk(clk), .rst_n(rst_n), .burst(burst), .smp_tick(smp_tick),
    .res_valid(res_valid), .conv_start(conv_start), .res_ready(res_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .last_wr(last_wr)
  );

  zcs_wave_store #(.N(N), .DW(DW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(conv_ch),
    .wr_idx(wr_idx), .wr_data(res_data), .rd_ch(rd_ch), .rd_idx(rd_idx),
    .rd_data(rd_data)
  );

  always_comb begin
    state_nx = state;
    done_nx  = 1'b0;
    err_nx   = 1'b0;
    unique case (state)
      S_IDLE: if (cap_req) state_nx = S_ARM_V;
      S_ARM_V, S_ARM_I: begin
        if (zc_pulse)    state_nx = (state == S_ARM_V) ? S_BURST_V : S_BURST_I;
        else if (expire) begin
          state_nx = S_IDLE;
          err_nx   = 1'b1;
        end
      end
      S_BURST_V: if (last_wr) state_nx = S_ARM_I;
      S_BURST_I: if (last_wr) begin
        state_nx = S_IDLE;
        done_nx  = 1'b1;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= done_nx;
      err_q  <= err_nx;
    end
  end

  // R10: done lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: done only follows the current burst
  a_r10_done_after_i: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == S_BURST_I));
  // R9: err only follows an arming cycle
  a_r9_err_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(arming));
  // R8: strobes only while hold-off is raised
  a_r8_hold_on_conv: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> hold_off);
  // R3: channel select does not change inside a burst
  a_r3_ch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && $past(burst)) |-> $stable(conv_ch));
  // R2: a crossing seen in idle without a request keeps the block idle
  a_r2_zc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && zc_pulse && !cap_req) |=> (state == S_IDLE));
endmodule

// File: tb/zc_two_pass_sampler_tb.sv
module zc_two_pass_sampler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 200;
  localparam int DW    = 12;
  localparam int TO_W  = 16;
  localparam int IW    = $clog2(N + 1);
  localparam int TICKP = 5;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_req = 1'b0, zc_pulse = 1'b0, smp_tick = 1'b0;
  logic [TO_W-1:0] arm_timeout = 16'd2000;
  logic conv_start, conv_ch, res_ready, hold_off, done, err;
  logic res_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic rd_ch = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [DW-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_two_pass_sampler #(.N(N), .DW(DW), .TO_W(TO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .zc_pulse(zc_pulse),
    .smp_tick(smp_tick), .arm_timeout(arm_timeout), .conv_start(conv_start),
    .conv_ch(conv_ch), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .hold_off(hold_off), .done(done), .err(err),
    .rd_ch(rd_ch), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  int total = 0, bad = 0, cyc = 0;
  int zc_mode = 0, zc_per = 700, zc_cnt = 0;
  bit stray_en = 1'b0;
  int tcnt = 0, adc_cnt = 0, vseq = 0, iseq = 0;
  logic adc_ch = 1'b0;

  // reference model state
  int m_st = 0, m_cnt = 0, m_iss = 0, m_wr = 0;
  bit m_pend = 0, m_done = 0, m_err = 0;
  int mbuf [2][N];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // stimulus sources: tick, zero crossings, ADC with stray beats
  always @(posedge clk) begin
    cyc <= cyc + 1;
    tcnt <= (tcnt == TICKP-1) ? 0 : tcnt + 1;
    smp_tick <= (tcnt == TICKP-1);
    zc_cnt <= (zc_cnt == zc_per-1) ? 0 : zc_cnt + 1;
    zc_pulse <= ((zc_mode != 0) && (zc_cnt == zc_per-1)) ||
                ((zc_mode == 2) && (adc_cnt == 1) && !adc_ch && (vseq == N-1));
    if (conv_start) begin
      adc_cnt <= LAT;
      adc_ch  <= conv_ch;
    end else if (adc_cnt > 0) adc_cnt <= adc_cnt - 1;
    if (adc_cnt == 1) begin
      res_valid <= 1'b1;
      if (adc_ch) begin res_data <= DW'(iseq*13 + 300); iseq <= iseq + 1; end
      else        begin res_data <= DW'(vseq*5 + 17);   vseq <= vseq + 1; end
    end else if (stray_en && adc_cnt == 0 && !conv_start && (cyc % 17 == 0)) begin
      res_valid <= 1'b1;
      res_data  <= 12'hBAD;
    end else res_valid <= 1'b0;
  end

  // cycle-by-cycle reference model
  always @(posedge clk) begin
    bit burst, cv, acc;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_iss = 0; m_wr = 0; m_pend = 0; m_done = 0; m_err = 0;
    end else begin
      burst = (m_st == 2 || m_st == 4);
      cv  = burst && smp_tick && !m_pend && (m_iss < N);
      acc = burst && res_valid && m_pend;
      m_done = 0; m_err = 0;
      case (m_st)
        0: if (cap_req) begin m_st = 1; m_cnt = 0; end
        1, 3: begin
          if (zc_pulse) begin m_st = m_st + 1; m_iss = 0; m_wr = 0; m_pend = 0; end
          else if (m_cnt == int'(arm_timeout)) begin m_st = 0; m_err = 1; end
          else m_cnt++;
        end
        default: begin
          if (acc) begin
            mbuf[(m_st == 4) ? 1 : 0][m_wr] = int'(res_data);
            m_wr++; m_pend = 0;
            if (m_wr == N) begin
              if (m_st == 2) begin m_st = 3; m_cnt = 0; end
              else begin m_st = 0; m_done = 1; end
            end
          end
          if (cv) begin m_pend = 1; m_iss++; end
        end
      endcase
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    bit eb, ec;
    if (rst_n) begin
      eb = (m_st == 2 || m_st == 4);
      ec = eb && smp_tick && !m_pend && (m_iss < N);
      chk(hold_off == eb, "R8 hold_off", hold_off, eb);
      chk(conv_start == ec, "R1 R2 R4 R5 R11 conv_start", conv_start, ec);
      if (ec) chk(conv_ch == (m_st == 4), "R3 conv_ch", conv_ch, m_st == 4);
      chk(res_ready == m_pend, "R7 res_ready", res_ready, m_pend);
      chk(done == m_done, "R10 done", done, m_done);
      chk(err == m_err, "R9 err", err, m_err);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  task automatic request();
    @(negedge clk); cap_req = 1'b1;
    @(negedge clk); cap_req = 1'b0;
  endtask

  task automatic readout();
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < N; k++) begin
        @(negedge clk); rd_ch = c[0]; rd_idx = IW'(k); #1;
        chk(int'(rd_data) == mbuf[c][k], "R6 rd_data", rd_data, mbuf[c][k]);
      end
      @(negedge clk); rd_idx = IW'(N); #1;
      chk(rd_data == '0, "R6 rd_data beyond N", rd_data, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({hold_off, conv_start, done, err, res_ready} == 5'b0, "R1 reset outputs",
        {hold_off, conv_start, done, err, res_ready}, 0);
    rst_n = 1'b1;

    // idle with crossings and ticks running: nothing must happen (R1, R2)
    zc_mode = 1; zc_per = 700; stray_en = 1'b1;
    repeat (800) @(negedge clk);

    // capture 1, with a request pulse during the burst (R11)
    request();
    while (!hold_off) @(negedge clk);
    repeat (50) @(negedge clk);
    cap_req = 1'b1; @(negedge clk); cap_req = 1'b0;
    while (!done) @(negedge clk);
    readout();

    // capture 2: crossing coincides with final voltage write (R4)
    zc_mode = 2; zc_per = 900; vseq = 0; iseq = 0;
    request();
    while (!done) @(negedge clk);
    readout();

    // timeout while arming the voltage pass (R9)
    zc_mode = 0; arm_timeout = 16'd30;
    request();
    repeat (60) @(negedge clk);

    // recovery: new capture after the error (R10)
    zc_mode = 1; zc_per = 700; arm_timeout = 16'd2000;
    request();
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    readout();
    summary();
  end
endmodule